// File: doc/BRIEF.md
# Dual-Channel Interrupt Context and Vector Unit

This unit sits between two serial channels and a host bus. Each channel raises a receiver request (with an error flag), a transmitter request, and a 3-bit code for its other event sources. The unit selects one winning source with a fixed priority and raises a single interrupt line. While the host runs an interrupt-acknowledge cycle, the unit drives a vector byte on the bus. That byte starts from a programmed base value, and a 2-bit mode field decides how much of it is overwritten with the channel number and the interrupt class.

On each acknowledge cycle, and on each update-context command, the unit freezes a snapshot of the winning interrupt into three byte-wide context registers: channel, type and byte count. These registers stay frozen until the next capture. Host reads from the shared receive-data port and host writes to the shared transmit-data port go to the FIFO of the channel held in that snapshot. The interrupt service routine therefore moves data without naming a channel.

Top module: `icv_unit`

## Requirements
- R1: When the vector mode is 00, bus_oe stays low. bus_oe is high only while iack is high and the mode is not 00. Whenever bus_oe is low, bus_vec is 0x00.
- R2: In mode 01, the vector driven during acknowledge equals the programmed base byte exactly.
- R3: In mode 10, vector bit 0 is the winning channel (0 = channel a, 1 = channel b). Bits 7:1 come from the base byte.
- R4: In mode 11, vector bit 0 is the channel and vector bits 2:1 are the winning class: 00 other or none, 01 transmitter, 10 receiver with errors, 11 receiver without errors. Bits 7:3 always come from the base byte.
- R5: The source priority is receiver first, then transmitter, then other events (a nonzero other-code).
- R6: When both channels request at the same priority level, channel a wins.
- R7: A snapshot is taken at the clock edge that ends an iack or upd_ctx cycle. Between captures, ctx_chan, ctx_type and ctx_count do not change. ctx_chan holds the channel in bit 0, and bits 7:1 are 0.
- R8: In ctx_type, bits 7:6 are 10 for a receiver interrupt with errors and 11 for one without errors. They are 00 for any non-receiver interrupt.
- R9: ctx_type bit 5 is set for a transmitter interrupt. For other events, bits 2:0 carry the channel's other-code. Bits 4:3 are always 0, and only one of these fields is nonzero.
- R10: For a receiver interrupt, ctx_count holds the channel's receive fill level. For a transmitter interrupt, it holds the channel's transmit free space. Levels 1..255 are stored as-is, 256 is stored as 0x00, and any other class stores 0x00.
- R11: grx_rd pulses rx_pop and gtx_wr pulses tx_push, only for the channel in the snapshot. grx_data returns that channel's receive byte.
- R12: irq is high exactly when at least one enabled source is pending. A disabled source neither raises irq nor wins arbitration. The enable bit for channel c and source s (s = 0 rx, 1 tx, 2 other) is cfg_src_en[3c+s].
- R13: After reset, all context registers read 0x00 and bus_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_vec_base | input | 8 | Programmed base vector byte |
| cfg_vec_mode | input | 2 | Vector modification mode |
| cfg_src_en | input | 6 | Source enables, bit 3c+s |
| rx_req | input | 2 | Receiver request per channel |
| rx_err | input | 2 | Receive error flag per channel |
| tx_req | input | 2 | Transmitter request per channel |
| oth_code | input | 6 | Other-event code, 3 bits per channel, channel a in bits 2:0 |
| rx_level | input | 18 | Receive fill level 1..256, 9 bits per channel |
| tx_space | input | 18 | Transmit free space 1..256, 9 bits per channel |
| iack | input | 1 | Interrupt-acknowledge cycle |
| upd_ctx | input | 1 | Update-context command |
| irq | output | 1 | Interrupt request |
| bus_vec | output | 8 | Vector byte |
| bus_oe | output | 1 | Vector output enable |
| ctx_chan | output | 8 | Captured channel register |
| ctx_type | output | 8 | Captured type register |
| ctx_count | output | 8 | Captured byte count register |
| grx_rd | input | 1 | Shared receive-port read strobe |
| gtx_wr | input | 1 | Shared transmit-port write strobe |
| rx_pop | output | 2 | Per-channel receive FIFO pop |
| tx_push | output | 2 | Per-channel transmit FIFO push |
| rx_data | input | 16 | Receive FIFO head bytes, channel a in bits 7:0 |
| grx_data | output | 8 | Receive byte of the captured channel |

## Verification
The bench runs each vector mode against inputs where bit 0 and bits 2:1 of the base already differ from the values that should be substituted. A design that overwrites the wrong mode or the wrong bit field therefore produces a visibly wrong byte. It places competing requests at equal and at different priority levels. A reversed channel order or class order would capture the wrong channel or type. A fill level of 256 must read back as 0x00, and an off-by-one encoding would show 0x01 or leak bit 8. Further cases check that a disabled source neither wins nor raises irq, that update-context captures without driving the bus, that the snapshot does not follow the live inputs, and that the FIFO strobes follow the captured channel and not the current winner.

// File: rtl/icv_pkg.sv
package icv_pkg;
    typedef enum logic [1:0] {
        VT_OTHER = 2'b00,
        VT_TX    = 2'b01,
        VT_RXERR = 2'b10,
        VT_RXOK  = 2'b11
    } vclass_e;

    localparam int SRC_RX  = 0;
    localparam int SRC_TX  = 1;
    localparam int SRC_OTH = 2;
    localparam int NSRC    = 3;
    localparam int OTW     = 3;
endpackage

// File: rtl/icv_arbiter.sv
module icv_arbiter
    import icv_pkg::*;
#(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]      rx_req,
    input  logic [NCH-1:0]      rx_err,
    input  logic [NCH-1:0]      tx_req,
    input  logic [NCH*OTW-1:0]  oth_code,
    input  logic [NCH*NSRC-1:0] src_en,
    output logic                any_pend,
    output logic [CHW-1:0]      win_ch,
    output vclass_e             win_cls,
    output logic [OTW-1:0]      win_oth
);
    logic [NCH-1:0] rx_m, tx_m, oth_m;

    for (genvar c = 0; c < NCH; c++) begin : g_mask
        assign rx_m[c]  = rx_req[c] & src_en[c*NSRC+SRC_RX];
        assign tx_m[c]  = tx_req[c] & src_en[c*NSRC+SRC_TX];
        assign oth_m[c] = (|oth_code[c*OTW +: OTW]) & src_en[c*NSRC+SRC_OTH];
    end

    logic           rx_hit, tx_hit, oth_hit;
    logic [CHW-1:0] rx_ch, tx_ch, oth_ch;

    always_comb begin
        rx_hit = 1'b0; tx_hit = 1'b0; oth_hit = 1'b0;
        rx_ch = '0; tx_ch = '0; oth_ch = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (rx_m[c])  begin rx_hit  = 1'b1; rx_ch  = CHW'(c); end
            if (tx_m[c])  begin tx_hit  = 1'b1; tx_ch  = CHW'(c); end
            if (oth_m[c]) begin oth_hit = 1'b1; oth_ch = CHW'(c); end
        end
    end

    always_comb begin
        win_ch  = '0;
        win_cls = VT_OTHER;
        win_oth = '0;
        if (rx_hit) begin
            win_ch  = rx_ch;
            win_cls = rx_err[rx_ch] ? VT_RXERR : VT_RXOK;
        end else if (tx_hit) begin
            win_ch  = tx_ch;
            win_cls = VT_TX;
        end else if (oth_hit) begin
            win_ch  = oth_ch;
            win_oth = oth_code[oth_ch*OTW +: OTW];
        end
    end

    assign any_pend = rx_hit | tx_hit | oth_hit;
endmodule

// File: rtl/icv_vector.sv
module icv_vector
    import icv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] base,
    input  logic [1:0]    mode,
    input  logic          chan,
    input  vclass_e       cls,
    input  logic          iack,
    output logic [DW-1:0] vec,
    output logic          oe
);
    logic [DW-1:0] formed;

    always_comb begin
        formed = base;
        if (mode[1])
            formed[0] = chan;
        if (mode == 2'b11)
            formed[2:1] = cls;
    end

    assign oe  = iack && (mode != 2'b00);
    assign vec = oe ? formed : '0;
endmodule

// File: rtl/icv_steer.sv
module icv_steer #(
    parameter int NCH = 2,
    parameter int DW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [CHW-1:0]    sel,
    input  logic              grx_rd,
    input  logic              gtx_wr,
    input  logic [NCH*DW-1:0] rx_data,
    output logic [NCH-1:0]    rx_pop,
    output logic [NCH-1:0]    tx_push,
    output logic [DW-1:0]     grx_data
);
    for (genvar c = 0; c < NCH; c++) begin : g_route
        assign rx_pop[c]  = grx_rd && (sel == CHW'(c));
        assign tx_push[c] = gtx_wr && (sel == CHW'(c));
    end

    assign grx_data = rx_data[sel*DW +: DW];
endmodule

// File: rtl/icv_unit.sv
module icv_unit
    import icv_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DW     = 8,
    parameter int FDEPTH = 256,
    localparam int CW  = $clog2(FDEPTH + 1),
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       cfg_vec_base,
    input  logic [1:0]          cfg_vec_mode,
    input  logic [NCH*NSRC-1:0] cfg_src_en,
    input  logic [NCH-1:0]      rx_req,
    input  logic [NCH-1:0]      rx_err,
    input  logic [NCH-1:0]      tx_req,
    input  logic [NCH*OTW-1:0]  oth_code,
    input  logic [NCH*CW-1:0]   rx_level,
    input  logic [NCH*CW-1:0]   tx_space,
    input  logic                iack,
    input  logic                upd_ctx,
    output logic                irq,
    output logic [DW-1:0]       bus_vec,
    output logic                bus_oe,
    output logic [DW-1:0]       ctx_chan,
    output logic [DW-1:0]       ctx_type,
    output logic [DW-1:0]       ctx_count,
    input  logic                grx_rd,
    input  logic                gtx_wr,
    output logic [NCH-1:0]      rx_pop,
    output logic [NCH-1:0]      tx_push,
    input  logic [NCH*DW-1:0]   rx_data,
    output logic [DW-1:0]       grx_data
);
    typedef struct packed {
        logic [CHW-1:0] chan;
        logic [DW-1:0]  typ;
        logic [DW-1:0]  cnt;
    } snap_t;

    snap_t snap_d, snap_q;

    logic           any_pend;
    logic [CHW-1:0] win_ch;
    vclass_e        win_cls;
    logic [OTW-1:0] win_oth;

    icv_arbiter #(.NCH(NCH)) u_arb (
        .rx_req   (rx_req),
        .rx_err   (rx_err),
        .tx_req   (tx_req),
        .oth_code (oth_code),
        .src_en   (cfg_src_en),
        .any_pend (any_pend),
        .win_ch   (win_ch),
        .win_cls  (win_cls),
        .win_oth  (win_oth)
    );

    icv_vector #(.DW(DW)) u_vec (
        .base (cfg_vec_base),
        .mode (cfg_vec_mode),
        .chan (win_ch[0]),
        .cls  (win_cls),
        .iack (iack),
        .vec  (bus_vec),
        .oe   (bus_oe)
    );

    logic [CW-1:0] lvl_sel;
    logic [DW-1:0] typ_new;

    always_comb begin
        typ_new = '0;
        lvl_sel = '0;
        unique case (win_cls)
            VT_RXERR: begin
                typ_new[7:6] = 2'b10;
                lvl_sel      = rx_level[win_ch*CW +: CW];
            end
            VT_RXOK: begin
                typ_new[7:6] = 2'b11;
                lvl_sel      = rx_level[win_ch*CW +: CW];
            end
            VT_TX: begin
                typ_new[5] = 1'b1;
                lvl_sel    = tx_space[win_ch*CW +: CW];
            end
            default: typ_new[2:0] = win_oth;
        endcase
    end

    always_comb begin
        snap_d = snap_q;
        if (iack || upd_ctx) begin
            snap_d.chan = win_ch;
            snap_d.typ  = typ_new;
            snap_d.cnt  = lvl_sel[CW-1] ? '0 : lvl_sel[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap_q <= '0;
        else
            snap_q <= snap_d;
    end

    assign irq       = any_pend;
    assign ctx_chan  = DW'(snap_q.chan);
    assign ctx_type  = snap_q.typ;
    assign ctx_count = snap_q.cnt;

    icv_steer #(.NCH(NCH), .DW(DW)) u_steer (
        .sel      (snap_q.chan),
        .grx_rd   (grx_rd),
        .gtx_wr   (gtx_wr),
        .rx_data  (rx_data),
        .rx_pop   (rx_pop),
        .tx_push  (tx_push),
        .grx_data (grx_data)
    );
endmodule

// File: rtl/icv_checker.sv
module icv_checker #(
    parameter int NCH = 2,
    parameter int DW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [DW-1:0]  cfg_vec_base,
    input logic [1:0]     cfg_vec_mode,
    input logic           iack,
    input logic           upd_ctx,
    input logic [DW-1:0]  bus_vec,
    input logic           bus_oe,
    input logic [DW-1:0]  ctx_chan,
    input logic [DW-1:0]  ctx_type,
    input logic [DW-1:0]  ctx_count,
    input logic           grx_rd,
    input logic [NCH-1:0] rx_pop,
    input logic [NCH-1:0] tx_push
);
    AST_OE_NEEDS_IACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (iack && cfg_vec_mode != 2'b00));  // R1
    AST_MODE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_vec_mode == 2'b00) |-> (!bus_oe && bus_vec == '0));  // R1
    AST_RAW_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && cfg_vec_mode == 2'b01) |-> (bus_vec == cfg_vec_base));  // R2
    AST_CHAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && cfg_vec_mode[1]) |=> (ctx_chan[0] == $past(bus_vec[0])));  // R3
    AST_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_vec[DW-1:3] == cfg_vec_base[DW-1:3]));  // R4
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!iack && !upd_ctx) |=> ($stable(ctx_chan) && $stable(ctx_type) && $stable(ctx_count)));  // R7
    AST_CHAN_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_chan[DW-1:1] == '0);  // R7
    AST_TYPE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_type[4:3] == 2'b00);  // R9
    AST_TYPE_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ctx_type[7], ctx_type[5], |ctx_type[2:0]}) <= 1);  // R9
    AST_RX_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_type[7] |-> !ctx_type[6]);  // R8
    AST_STEER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop) && $onehot0(tx_push));  // R11
    AST_POP_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_pop) |-> grx_rd);  // R11
endmodule

bind icv_unit icv_checker #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/tb_icv_unit.sv
module tb_icv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_vec_base = 8'hAA;
    logic [1:0]  cfg_vec_mode = 2'b00;
    logic [5:0]  cfg_src_en = 6'o77;
    logic [1:0]  rx_req = '0, rx_err = '0, tx_req = '0;
    logic [5:0]  oth_code = '0;
    logic [17:0] rx_level = {9'd256, 9'd5};
    logic [17:0] tx_space = {9'd200, 9'd1};
    logic        iack = 1'b0, upd_ctx = 1'b0, grx_rd = 1'b0, gtx_wr = 1'b0;
    logic [15:0] rx_data = {8'h5B, 8'h3C};
    logic        irq, bus_oe;
    logic [7:0]  bus_vec, ctx_chan, ctx_type, ctx_count, grx_data;
    logic [1:0]  rx_pop, tx_push;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    icv_unit dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] rxr, rxe, txr;
        logic [5:0] oth, en;
        logic       oe;
        logic [7:0] vec, typ;
        logic       chan;
        logic [7:0] cnt;
    } row_t;

    localparam int NROW = 10;
    localparam row_t TBL [NROW] = '{
        '{2'd1, 2'b01, 2'b00, 2'b00, 6'o00, 6'o77, 1'b1, 8'hAA, 8'hC0, 1'b0, 8'h05},
        '{2'd2, 2'b10, 2'b10, 2'b00, 6'o00, 6'o77, 1'b1, 8'hAB, 8'h80, 1'b1, 8'h00},
        '{2'd3, 2'b10, 2'b00, 2'b01, 6'o00, 6'o77, 1'b1, 8'hAF, 8'hC0, 1'b1, 8'h00},
        '{2'd3, 2'b00, 2'b00, 2'b11, 6'o00, 6'o77, 1'b1, 8'hAA, 8'h20, 1'b0, 8'h01},
        '{2'd3, 2'b00, 2'b00, 2'b10, 6'o05, 6'o77, 1'b1, 8'hAB, 8'h20, 1'b1, 8'hC8},
        '{2'd3, 2'b00, 2'b00, 2'b00, 6'o63, 6'o77, 1'b1, 8'hA8, 8'h03, 1'b0, 8'h00},
        '{2'd3, 2'b00, 2'b00, 2'b00, 6'o70, 6'o77, 1'b1, 8'hA9, 8'h07, 1'b1, 8'h00},
        '{2'd0, 2'b01, 2'b01, 2'b00, 6'o00, 6'o77, 1'b0, 8'h00, 8'h80, 1'b0, 8'h05},
        '{2'd2, 2'b01, 2'b00, 2'b10, 6'o00, 6'o76, 1'b1, 8'hAB, 8'h20, 1'b1, 8'hC8},
        '{2'd3, 2'b11, 2'b01, 2'b00, 6'o00, 6'o77, 1'b1, 8'hAC, 8'h80, 1'b0, 8'h05}
    };

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R13 ctx_chan", ctx_chan, 8'h00);
        check("R13 ctx_type", ctx_type, 8'h00);
        check("R13 ctx_count", ctx_count, 8'h00);
        check("R13 bus_oe", bus_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: modes R1-style zero output, R2 raw, R3/R4 substitution, R5/R6 priority, R8-R10 snapshot
        for (int i = 0; i < NROW; i++) begin
            cfg_vec_mode = TBL[i].mode;
            rx_req = TBL[i].rxr; rx_err = TBL[i].rxe; tx_req = TBL[i].txr;
            oth_code = TBL[i].oth; cfg_src_en = TBL[i].en;
            iack = 1'b1;
            #2;
            check("R12 irq", irq, 1'b1);
            check("R1 bus_oe", bus_oe, TBL[i].oe);
            check("R2/R3/R4 bus_vec", bus_vec, TBL[i].vec);
            @(negedge clk);
            iack = 1'b0;
            #2;
            check("R7/R5/R6 ctx_chan", ctx_chan, {7'b0, TBL[i].chan});
            check("R8/R9 ctx_type", ctx_type, TBL[i].typ);
            check("R10 ctx_count", ctx_count, TBL[i].cnt);
            @(negedge clk);
        end

        // R12: disabled and zero-code sources raise nothing
        rx_req = 2'b11; tx_req = 2'b11; oth_code = 6'o77; cfg_src_en = 6'o00;
        #2 check("R12 all disabled irq", irq, 1'b0);
        rx_req = 2'b00; tx_req = 2'b00; oth_code = 6'o00; cfg_src_en = 6'o77;
        #2 check("R12 zero other code irq", irq, 1'b0);
        @(negedge clk);

        // R7: update command captures without driving the bus
        cfg_vec_mode = 2'b11; rx_req = 2'b10; rx_err = 2'b00;
        upd_ctx = 1'b1;
        #2 check("R1 no oe on update", bus_oe, 1'b0);
        @(negedge clk);
        upd_ctx = 1'b0;
        #2;
        check("R7 update chan", ctx_chan, 8'h01);
        check("R7 update type", ctx_type, 8'hC0);
        check("R10 update count 256", ctx_count, 8'h00);

        // R7: snapshot holds while live inputs change
        rx_req = 2'b00; tx_req = 2'b01;
        repeat (2) @(negedge clk);
        #2;
        check("R7 hold chan", ctx_chan, 8'h01);
        check("R7 hold type", ctx_type, 8'hC0);

        // R11: steering follows the snapshot, not the live winner (tx a)
        grx_rd = 1'b1; gtx_wr = 1'b1;
        #2;
        check("R11 rx_pop chan b", rx_pop, 2'b10);
        check("R11 tx_push chan b", tx_push, 2'b10);
        check("R11 grx_data chan b", grx_data, 8'h5B);
        grx_rd = 1'b0; gtx_wr = 1'b0;
        #2 check("R11 idle pops", {rx_pop, tx_push}, 4'b0000);
        @(negedge clk);
        tx_req = 2'b00; rx_req = 2'b01;
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0; grx_rd = 1'b1;
        #2;
        check("R11 rx_pop chan a", rx_pop, 2'b01);
        check("R11 grx_data chan a", grx_data, 8'h3C);
        grx_rd = 1'b0;
        @(negedge clk);

        // R4/R10: acknowledge with nothing pending
        rx_req = 2'b00;
        iack = 1'b1;
        #2 check("R4 empty vector", bus_vec, 8'hA8);
        @(negedge clk);
        iack = 1'b0;
        #2;
        check("R9 empty type", ctx_type, 8'h00);
        check("R10 empty count", ctx_count, 8'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule